// File: doc/BRIEF.md
# Receive AIS Consequent-Action Controller

This block sits at the receive side of a line terminal and turns defect levels into consequent actions. Four local defects feed a common persistence trigger: loss of frame alignment, an error ratio worse than 1 in 10^3, line signal fail and receive forward fail. When that trigger has held without a break for longer than a programmable number of millisecond ticks (250 by default), the block starts replacing the receive data with AIS. It also raises a system-fail output and reports the AIS-inject alarm to management.

A distant alarm from the far end also forces AIS. It does this at once, without the persistence rule and without the management alarm. Whenever AIS is active, the timing source moves to the external 2 MHz reference. The reverse alarm bit in the transmit overhead is then set, unless the distant alarm is present. Every output comes straight from a flip-flop.

Top module: `rx_ais_ctrl`

## Requirements
- R1: Each of `lof_i`, `ber_high_i`, `line_fail_i` and `fwd_fail_i` acts on its own as the persistence trigger; the trigger is the OR of the four.
- R2: With the trigger held high, `sys_fail_o`, `ais_alarm_o` and `ais_en_o` rise on the clock edge that samples the (PERSIST_TICKS+1)th `tick_ms_i` pulse. They do not rise on any earlier pulse, nor in cycles without a tick.
- R3: Any clock cycle in which the trigger is low restarts the persistence count from zero.
- R4: Once the persistent state is set, it stays set until the first tick that is sampled while the trigger is low, and it clears on that edge. A low trigger with no tick leaves the state set.
- R5: `distant_i` high drives `ais_en_o` high on the next edge, and it stops doing so on the edge after `distant_i` falls. It never raises `sys_fail_o` or `ais_alarm_o`.
- R6: `tsrc_ext_o` (1 = external 2 MHz reference, 0 = recovered receive timing) equals `ais_en_o` in every cycle.
- R7: `rev_alarm_o` is high exactly when AIS is active and `distant_i` was low at the same edge.
- R8: Ticks with no trigger and no distant alarm leave every output low.
- R9: During and straight after reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_ms_i | input | 1 | One-cycle pulse per millisecond |
| lof_i | input | 1 | Loss of frame alignment defect |
| ber_high_i | input | 1 | Error ratio worse than 1 in 10^3 |
| line_fail_i | input | 1 | Line signal fail from receiver |
| fwd_fail_i | input | 1 | Receive forward fail defect |
| distant_i | input | 1 | Receive distant alarm from far end |
| ais_en_o | output | 1 | Replace receive data with AIS |
| sys_fail_o | output | 1 | System-fail output |
| rev_alarm_o | output | 1 | Reverse alarm bit for transmit overhead |
| tsrc_ext_o | output | 1 | Timing source select, 1 = external reference |
| ais_alarm_o | output | 1 | AIS-inject alarm to management |

## Verification
The bench builds the block with PERSIST_TICKS = 6. That brings the exact boundary tick, the saturation of the counter and its restart within a few dozen cycles. Each of the four trigger sources is swept over every tick count from 1 to PERSIST_TICKS+1, and the expected outputs come from the comparison of the tick count with the limit. The distant alarm is combined with both the idle and the persistent state, so that the masking of the reverse bit and the alarm can be compared with arithmetic expectations.

// File: rtl/rx_ais_pkg.sv
package rx_ais_pkg;

   typedef enum logic {
      TSRC_RECOVERED = 1'b0,
      TSRC_EXTERNAL  = 1'b1
   } tsrc_e;

   typedef struct packed {
      logic  ais;
      logic  sysfail;
      logic  rev;
      tsrc_e tsrc;
      logic  alarm;
   } rx_act_t;

   localparam rx_act_t ACT_IDLE = '{ais: 1'b0, sysfail: 1'b0, rev: 1'b0,
                                    tsrc: TSRC_RECOVERED, alarm: 1'b0};

   function automatic rx_act_t derive_act(input logic persist, input logic distant);
      rx_act_t a;
      a.ais     = persist | distant;
      a.sysfail = persist;
      a.alarm   = persist;
      a.rev     = (persist | distant) & ~distant;
      a.tsrc    = (persist | distant) ? TSRC_EXTERNAL : TSRC_RECOVERED;
      return a;
   endfunction

endpackage

// File: rtl/rx_ais_persist.sv
module rx_ais_persist #(
   parameter int PERSIST_TICKS = 250
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic trig_i,
   output logic persist_nxt_o
);
   localparam int CNT_W = $clog2(PERSIST_TICKS + 2);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(PERSIST_TICKS);

   logic [CNT_W-1:0] cnt_q;
   logic             persist_q;
   logic             limit_hit;

   assign limit_hit = trig_i & tick_i & (cnt_q == LIMIT);

   always_comb begin
      if (trig_i)
         persist_nxt_o = persist_q | limit_hit;
      else if (tick_i)
         persist_nxt_o = 1'b0;
      else
         persist_nxt_o = persist_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         persist_q <= 1'b0;
      end else begin
         persist_q <= persist_nxt_o;
         if (!trig_i)
            cnt_q <= '0;
         else if (tick_i && cnt_q <= LIMIT)
            cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/rx_ais_outreg.sv
module rx_ais_outreg
   import rx_ais_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    persist_i,
   input  logic    distant_i,
   output rx_act_t act_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         act_o <= ACT_IDLE;
      else
         act_o <= derive_act(persist_i, distant_i);
   end
endmodule

// File: rtl/rx_ais_ctrl.sv
module rx_ais_ctrl
   import rx_ais_pkg::*;
#(
   parameter int PERSIST_TICKS = 250,
   parameter int N_LOCAL       = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_ms_i,
   input  logic lof_i,
   input  logic ber_high_i,
   input  logic line_fail_i,
   input  logic fwd_fail_i,
   input  logic distant_i,
   output logic ais_en_o,
   output logic sys_fail_o,
   output logic rev_alarm_o,
   output logic tsrc_ext_o,
   output logic ais_alarm_o
);
   initial begin
      if (PERSIST_TICKS < 1)
         $error("PERSIST_TICKS must be at least 1");
      if (N_LOCAL != 4)
         $error("N_LOCAL must match the four local defect ports");
   end

   logic [N_LOCAL-1:0] defect_vec;
   logic [N_LOCAL:0]   or_chain;
   logic               trig;
   logic               persist_nxt;
   rx_act_t            act;

   assign defect_vec = {fwd_fail_i, line_fail_i, ber_high_i, lof_i};
   assign or_chain[0] = 1'b0;

   for (genvar g = 0; g < N_LOCAL; g++) begin : g_trig_or
      assign or_chain[g+1] = or_chain[g] | defect_vec[g];
   end

   assign trig = or_chain[N_LOCAL];

   rx_ais_persist #(
      .PERSIST_TICKS(PERSIST_TICKS)
   ) i_persist (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick_i       (tick_ms_i),
      .trig_i       (trig),
      .persist_nxt_o(persist_nxt)
   );

   rx_ais_outreg i_outreg (
      .clk      (clk),
      .rst_n    (rst_n),
      .persist_i(persist_nxt),
      .distant_i(distant_i),
      .act_o    (act)
   );

   assign ais_en_o    = act.ais;
   assign sys_fail_o  = act.sysfail;
   assign rev_alarm_o = act.rev;
   assign tsrc_ext_o  = (act.tsrc == TSRC_EXTERNAL);
   assign ais_alarm_o = act.alarm;
endmodule

// File: rtl/rx_ais_ctrl_chk.sv
module rx_ais_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic tick_ms_i,
   input logic lof_i,
   input logic ber_high_i,
   input logic line_fail_i,
   input logic fwd_fail_i,
   input logic distant_i,
   input logic ais_en_o,
   input logic sys_fail_o,
   input logic rev_alarm_o,
   input logic tsrc_ext_o,
   input logic ais_alarm_o
);
   logic trig_any;
   assign trig_any = lof_i | ber_high_i | line_fail_i | fwd_fail_i;

   p_tsrc_follows_ais_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tsrc_ext_o == ais_en_o);

   p_rev_needs_ais_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rev_alarm_o |-> ais_en_o);

   p_sysfail_implies_ais_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sys_fail_o |-> (ais_en_o && ais_alarm_o));

   p_distant_forces_ais_r5: assert property (@(posedge clk) disable iff (!rst_n)
      distant_i |=> (ais_en_o && !rev_alarm_o));

   p_rise_needs_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sys_fail_o) |-> ($past(tick_ms_i) && $past(trig_any)));

   p_clear_needs_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sys_fail_o) |-> ($past(tick_ms_i) && !$past(trig_any)));

   p_quiet_no_ais_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!trig_any && !distant_i && !sys_fail_o) |=> !ais_en_o);
endmodule

bind rx_ais_ctrl rx_ais_ctrl_chk i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick_ms_i  (tick_ms_i),
   .lof_i      (lof_i),
   .ber_high_i (ber_high_i),
   .line_fail_i(line_fail_i),
   .fwd_fail_i (fwd_fail_i),
   .distant_i  (distant_i),
   .ais_en_o   (ais_en_o),
   .sys_fail_o (sys_fail_o),
   .rev_alarm_o(rev_alarm_o),
   .tsrc_ext_o (tsrc_ext_o),
   .ais_alarm_o(ais_alarm_o)
);

// File: tb/test_rx_ais_ctrl.sv
module test_rx_ais_ctrl;
   localparam int N = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0;
   logic [3:0] dfx = '0;
   logic distant = 1'b0;
   logic ais, sf, rev, ts, al;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #4 clk = ~clk;

   rx_ais_ctrl #(.PERSIST_TICKS(N)) i_rx_ais_ctrl (
      .clk(clk), .rst_n(rst_n), .tick_ms_i(tick),
      .lof_i(dfx[0]), .ber_high_i(dfx[1]), .line_fail_i(dfx[2]), .fwd_fail_i(dfx[3]),
      .distant_i(distant),
      .ais_en_o(ais), .sys_fail_o(sf), .rev_alarm_o(rev), .tsrc_ext_o(ts), .ais_alarm_o(al)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic step(input logic t);
      tick = t;
      @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic expect5(input string req, input logic e_ais, input logic e_sf,
                          input logic e_rev, input logic e_ts, input logic e_al);
      checks++;
      if ({ais, sf, rev, ts, al} !== {e_ais, e_sf, e_rev, e_ts, e_al}) begin
         errors++;
         $display("FAIL %s: ais/sf/rev/ts/al actual %b%b%b%b%b expected %b%b%b%b%b",
                  req, ais, sf, rev, ts, al, e_ais, e_sf, e_rev, e_ts, e_al);
      end
   endtask

   initial begin
      @(negedge clk);
      @(negedge clk);
      expect5("R9 in reset", 0, 0, 0, 0, 0);
      rst_n = 1'b1;
      @(negedge clk);
      expect5("R9 after reset", 0, 0, 0, 0, 0);

      // R8: ticks alone
      for (int i = 0; i < 10; i++) step(1'b1);
      expect5("R8 ticks only", 0, 0, 0, 0, 0);

      // R1 / R2: each source, every tick count
      for (int s = 0; s < 4; s++) begin
         dfx = 4'b0001 << s;
         for (int k = 1; k <= N + 1; k++) begin
            logic e;
            step(1'b1);
            e = (k > N);
            expect5($sformatf("R1 R2 src %0d tick %0d", s, k), e, e, e, e, e);
         end
         dfx = '0;
         step(1'b0);
         expect5("R4 hold without tick", 1, 1, 1, 1, 1);
         step(1'b1);
         expect5("R4 clear on tick", 0, 0, 0, 0, 0);
      end

      // R3: one low cycle restarts the count
      dfx = 4'b0100;
      for (int k = 0; k < N; k++) step(1'b1);
      dfx = '0;
      step(1'b0);
      dfx = 4'b1000;
      for (int k = 0; k < N; k++) step(1'b1);
      expect5("R3 restart after break", 0, 0, 0, 0, 0);
      step(1'b1);
      expect5("R3 full count after break", 1, 1, 1, 1, 1);

      // R4: trigger returns before any tick while low
      dfx = '0;
      step(1'b0);
      dfx = 4'b0010;
      step(1'b1);
      expect5("R4 no tick while low keeps state", 1, 1, 1, 1, 1);
      dfx = '0;
      step(1'b1);
      expect5("R4 cleared", 0, 0, 0, 0, 0);

      // R2: trigger with no ticks never persists
      dfx = 4'b1111;
      for (int k = 0; k < 20; k++) step(1'b0);
      expect5("R2 no ticks", 0, 0, 0, 0, 0);
      dfx = '0;
      step(1'b1);

      // R5 / R7: distant alone
      distant = 1'b1;
      step(1'b0);
      expect5("R5 R7 distant alone", 1, 0, 0, 1, 0);
      distant = 1'b0;
      step(1'b0);
      expect5("R5 distant removed", 0, 0, 0, 0, 0);

      // R7: distant together with the persistent state
      distant = 1'b1;
      dfx = 4'b0001;
      for (int k = 0; k < N + 1; k++) step(1'b1);
      expect5("R7 persist with distant", 1, 1, 0, 1, 1);
      distant = 1'b0;
      step(1'b0);
      expect5("R7 distant cleared rev set", 1, 1, 1, 1, 1);
      dfx = '0;
      step(1'b1);
      expect5("R4 R6 final clear", 0, 0, 0, 0, 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule